// File: doc/BRIEF.md
# Sequencer Arithmetic and Branch Unit

This unit is the execute stage for the arithmetic and flow-control part of a byte-coded sequencer. A decoder in front of it has already fetched the instruction and resolved every operand to a 16-bit value: the destination register index, the branch target, and the two source operands. The unit classifies the 8-bit opcode and computes a result or a branch decision. One cycle later it presents a register write, a branch indication and the next program counter.

Sum, difference, signed product, signed quotient and increment/decrement results go out on a register write port to a register file of at least 200 entries. A multiplication also drives a second write port that places the upper half of the 32-bit product into a fixed register, index 199. Conditional branches compare signed values. When a branch is not taken, the program counter advances by the byte length of the whole instruction. The unit works out that length from the immediate/register flag bits of the opcode. A division by zero sets a sticky error flag that only reset clears.

Top module: `seqx_exec_unit`

## Requirements
- R1: When `in_valid` is high in a cycle, `out_done` and all results are presented in the following cycle only. A cycle without `in_valid` is followed by `out_done`, `wr_en`, `hi_en` and `br_taken` all low.
- R2: Opcodes 01/03/05/07 write `in_a + in_b` and opcodes 11/13/15/17 write `in_a - in_b` to register `in_dst`, both modulo 2^16.
- R3: Opcodes 21/23/25/27 form the signed 32-bit product of `in_a` and `in_b`. The low half is written to `in_dst`. In the same cycle `hi_en` is raised with `hi_addr` = 199 and `hi_data` = the high half.
- R4: Opcodes 31/33/35/37 write the signed quotient `in_a / in_b`, rounded toward zero. The case 0x8000 / 0xFFFF yields 0x8000.
- R5: A division with `in_b` = 0 writes 0xFFFF and sets `div_err`. `div_err` then stays high through later instructions until reset.
- R6: Opcode C6 writes `in_a + 1` and opcode D0 writes `in_a - 1` to `in_dst`, modulo 2^16. For these two opcodes `in_a` carries the current value of the destination register.
- R7: An opcode whose low nibble is 0, 2, 8 or A and whose high nibble is 0 to 5 is a compare branch. Bits 6:4 select the test of `in_a` against `in_b`: 0 equal, 1 not equal, 2 less, 3 less or equal, 4 greater, 5 greater or equal. The test uses signed 16-bit values. When it holds, `br_taken` is high and `br_target` = `in_tgt`.
- R8: Opcodes 82/86 branch when `in_a` is nonzero, 90/98 branch when `in_a` is zero, and C2/CA always branch.
- R9: When a branch is taken, `next_pc` = `in_tgt`. Otherwise `next_pc` = `in_pc` + length. The length counts one byte for the opcode plus each operand: 2 bytes if immediate, 1 if register. The immediate flags are: arithmetic, bit 2 for operand 2 and bit 1 for operand 3 (operand 1 always register); compare branch, bit 3 for operand 1 and bit 1 for operand 3; 82/86, bit 2 for operand 1; 90/98 and C2/CA, bit 3 for operand 1. C6 and D0 are 2 bytes long.
- R10: Branch opcodes and unrecognised opcodes raise neither `wr_en` nor `hi_en`. An unrecognised opcode does not branch and gives `next_pc` = `in_pc` + 1.
- R11: While `rst_n` is low on a clock edge, every output is cleared to zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A decoded instruction is present |
| in_opcode | input | 8 | Instruction opcode |
| in_pc | input | 16 | Address of the instruction's opcode byte |
| in_dst | input | 8 | Destination register index (operand 1) |
| in_tgt | input | 16 | Resolved branch target (operand 1) |
| in_a | input | 16 | Resolved operand 2 |
| in_b | input | 16 | Resolved operand 3 |
| out_done | output | 1 | Results of the previous cycle's instruction are valid |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 8 | Register write index |
| wr_data | output | 16 | Register write value |
| hi_en | output | 1 | Write strobe for the product high half |
| hi_addr | output | 8 | Fixed index of the product high-half register |
| hi_data | output | 16 | Product high half |
| br_taken | output | 1 | Branch taken |
| br_target | output | 16 | Branch destination |
| next_pc | output | 16 | Address of the next instruction |
| div_err | output | 1 | Sticky division-by-zero flag |

## Verification
The bench uses an operand pair of 0xFFFF and 0x0001 on less-than and greater-or-equal. A design that compared unsigned values would reverse both decisions. It divides -7 by 2, where a floor divider would give -4, and divides 0x8000 by -1, where a careless overflow path would produce garbage. Multiplications with a negative factor expose a missing sign extension in the high half sent to register 199. Not-taken branches cover each immediate-flag layout, so a length table keyed to the wrong opcode bit gives a wrong `next_pc`. Further checks confirm that the division error flag survives a later good division and clears only on reset, and that branches and an unknown opcode never write a register.

// File: rtl/seqx_pkg.sv
// Package: shared types and helpers for the sequencer execute unit.
// Assumes an 8-bit opcode and byte-addressed instruction memory.
package seqx_pkg;

    typedef enum logic [2:0] {
        K_NONE,     // not handled here
        K_ARITH,    // three-operand arithmetic
        K_STEP,     // increment / decrement
        K_CMPBR,    // compare two operands, branch
        K_NZBR,     // branch if nonzero
        K_ZBR,      // branch if zero
        K_JUMP      // unconditional branch
    } kind_e;

    typedef enum logic [1:0] {
        A_ADD = 2'd0,
        A_SUB = 2'd1,
        A_MUL = 2'd2,
        A_DIV = 2'd3
    } alu_e;

    typedef enum logic [2:0] {
        C_EQ = 3'd0,
        C_NE = 3'd1,
        C_LT = 3'd2,
        C_LE = 3'd3,
        C_GT = 3'd4,
        C_GE = 3'd5
    } cmp_e;

    typedef struct packed {
        kind_e       kind;
        alu_e        alu;
        cmp_e        cmp;
        logic        step_down;
        logic [2:0]  len;     // instruction length in bytes
    } dec_t;

    // Byte size of one operand field given its immediate flag.
    function automatic logic [2:0] fld_sz(input logic imm);
        return imm ? 3'd2 : 3'd1;
    endfunction

endpackage

// File: rtl/seqx_decode.sv
// Module: seqx_decode
// Classifies an opcode into an operation kind, the arithmetic or compare
// selector, and the total instruction length. Purely combinational.
// Assumes registers are encoded in one byte and immediates in two.
module seqx_decode
    import seqx_pkg::*;
(
    input  logic [7:0] opcode,
    output dec_t       dec
);

    logic hi_lo;       // high nibble within 0..5
    logic is_arith;
    logic is_cmp;

    assign hi_lo    = (opcode[7:4] <= 4'd5);
    assign is_arith = (opcode[7:6] == 2'b00) && !opcode[3] && opcode[0];
    assign is_cmp   = hi_lo && !opcode[2] && !opcode[0];

    // Select kind, sub-operation and byte length from the opcode.
    always_comb begin
        dec           = '0;
        dec.kind      = K_NONE;
        dec.alu       = alu_e'(opcode[5:4]);
        dec.cmp       = cmp_e'(opcode[6:4]);
        dec.step_down = 1'b0;
        dec.len       = 3'd1;
        if (is_arith) begin
            dec.kind = K_ARITH;
            dec.len  = 3'd2 + fld_sz(opcode[2]) + fld_sz(opcode[1]);
        end else if (is_cmp) begin
            dec.kind = K_CMPBR;
            dec.len  = 3'd2 + fld_sz(opcode[3]) + fld_sz(opcode[1]);
        end else begin
            unique case (opcode)
                8'hC6, 8'hD0: begin
                    dec.kind      = K_STEP;
                    dec.step_down = (opcode == 8'hD0);
                    dec.len       = 3'd2;
                end
                8'h82, 8'h86: begin
                    dec.kind = K_NZBR;
                    dec.len  = 3'd2 + fld_sz(opcode[2]);
                end
                8'h90, 8'h98: begin
                    dec.kind = K_ZBR;
                    dec.len  = 3'd2 + fld_sz(opcode[3]);
                end
                8'hC2, 8'hCA: begin
                    dec.kind = K_JUMP;
                    dec.len  = 3'd1 + fld_sz(opcode[3]);
                end
                default: dec.kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/seqx_arith.sv
// Module: seqx_arith
// Computes sum, difference, signed product and signed quotient of two
// operands. Combinational. Division by zero returns all ones and flags it;
// the single overflowing quotient (most negative / -1) returns the dividend.
module seqx_arith
    import seqx_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_e          op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] lo,
    output logic [DW-1:0] hi,
    output logic          dz
);

    localparam int PW = 2 * DW;
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    logic [PW-1:0] ax, bx, prod;
    logic [DW-1:0] quot;

    assign ax   = PW'($signed(a));
    assign bx   = PW'($signed(b));
    assign prod = ax * bx;

    // Signed quotient with the zero divisor and overflow cases guarded.
    always_comb begin
        if (b == '0)
            quot = '1;
        else if (a == MOST_NEG && b == '1)
            quot = a;
        else
            quot = $signed(a) / $signed(b);
    end

    // Select the result of the requested operation.
    always_comb begin
        hi = prod[PW-1:DW];
        dz = (op == A_DIV) && (b == '0);
        unique case (op)
            A_ADD:   lo = a + b;
            A_SUB:   lo = a - b;
            A_MUL:   lo = prod[DW-1:0];
            default: lo = quot;
        endcase
    end

endmodule

// File: rtl/seqx_cond.sv
// Module: seqx_cond
// Decides whether a branch is taken. Compare branches use signed operands;
// zero tests look at operand a only. Combinational.
module seqx_cond
    import seqx_pkg::*;
#(
    parameter int DW = 16
) (
    input  kind_e         kind,
    input  cmp_e          cmp,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic          take
);

    logic eq, lt;

    assign eq = (a == b);
    assign lt = ($signed(a) < $signed(b));

    // Evaluate the branch condition for the decoded kind.
    always_comb begin
        take = 1'b0;
        unique case (kind)
            K_CMPBR: begin
                unique case (cmp)
                    C_EQ:    take = eq;
                    C_NE:    take = !eq;
                    C_LT:    take = lt;
                    C_LE:    take = lt || eq;
                    C_GT:    take = !lt && !eq;
                    C_GE:    take = !lt;
                    default: take = 1'b0;
                endcase
            end
            K_NZBR:  take = (a != '0);
            K_ZBR:   take = (a == '0);
            K_JUMP:  take = 1'b1;
            default: take = 1'b0;
        endcase
    end

endmodule

// File: rtl/seqx_exec_unit.sv
// Module: seqx_exec_unit (top)
// Execute stage for arithmetic and branch instructions. Takes a decoded
// instruction with resolved operands and, one cycle later, presents the
// register write(s), branch decision and next program counter.
// Assumes the register file holds more than HI_REG entries and that the
// decoder supplies the destination's current value on in_a for INC/DEC.
module seqx_exec_unit
    import seqx_pkg::*;
#(
    parameter int DW     = 16,
    parameter int RW     = 8,
    parameter int PCW    = 16,
    parameter int HI_REG = 199
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [7:0]     in_opcode,
    input  logic [PCW-1:0] in_pc,
    input  logic [RW-1:0]  in_dst,
    input  logic [PCW-1:0] in_tgt,
    input  logic [DW-1:0]  in_a,
    input  logic [DW-1:0]  in_b,
    output logic           out_done,
    output logic           wr_en,
    output logic [RW-1:0]  wr_addr,
    output logic [DW-1:0]  wr_data,
    output logic           hi_en,
    output logic [RW-1:0]  hi_addr,
    output logic [DW-1:0]  hi_data,
    output logic           br_taken,
    output logic [PCW-1:0] br_target,
    output logic [PCW-1:0] next_pc,
    output logic           div_err
);

    localparam logic [RW-1:0] HI_IDX = RW'(HI_REG);

    dec_t          dec;
    alu_e          alu_sel;
    logic [DW-1:0] b_eff, res_lo, res_hi;
    logic          res_dz, take, writes;

    seqx_decode i_dec (
        .opcode (in_opcode),
        .dec    (dec)
    );

    // Increment/decrement reuse the adder with a unit second operand.
    always_comb begin
        if (dec.kind == K_STEP) begin
            alu_sel = dec.step_down ? A_SUB : A_ADD;
            b_eff   = DW'(1);
        end else begin
            alu_sel = dec.alu;
            b_eff   = in_b;
        end
    end

    seqx_arith #(.DW(DW)) i_arith (
        .op (alu_sel),
        .a  (in_a),
        .b  (b_eff),
        .lo (res_lo),
        .hi (res_hi),
        .dz (res_dz)
    );

    seqx_cond #(.DW(DW)) i_cond (
        .kind (dec.kind),
        .cmp  (dec.cmp),
        .a    (in_a),
        .b    (in_b),
        .take (take)
    );

    assign writes  = (dec.kind == K_ARITH) || (dec.kind == K_STEP);
    assign hi_addr = HI_IDX;

    // Register all results for one cycle after an accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_done  <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            hi_en     <= 1'b0;
            hi_data   <= '0;
            br_taken  <= 1'b0;
            br_target <= '0;
            next_pc   <= '0;
        end else begin
            out_done  <= in_valid;
            wr_en     <= in_valid && writes;
            wr_addr   <= in_dst;
            wr_data   <= res_lo;
            hi_en     <= in_valid && (dec.kind == K_ARITH) && (dec.alu == A_MUL);
            hi_data   <= res_hi;
            br_taken  <= in_valid && take;
            br_target <= in_tgt;
            next_pc   <= take ? in_tgt : in_pc + PCW'(dec.len);
        end
    end

    // Hold the division-by-zero flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_err <= 1'b0;
        else if (in_valid && dec.kind == K_ARITH && res_dz)
            div_err <= 1'b1;
    end

endmodule

// File: rtl/seqx_exec_chk.sv
// Module: seqx_exec_chk
// Temporal checks on the execute unit's ports, attached by bind below.
// Decodes only the few opcodes it needs, straight from the port value.
module seqx_exec_chk #(
    parameter int DW     = 16,
    parameter int RW     = 8,
    parameter int PCW    = 16,
    parameter int HI_REG = 199
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [7:0]     in_opcode,
    input logic [PCW-1:0] in_tgt,
    input logic [DW-1:0]  in_b,
    input logic           out_done,
    input logic           wr_en,
    input logic [DW-1:0]  wr_data,
    input logic           hi_en,
    input logic [RW-1:0]  hi_addr,
    input logic           br_taken,
    input logic [PCW-1:0] br_target,
    input logic [PCW-1:0] next_pc,
    input logic           div_err
);

    logic div_op;
    assign div_op = (in_opcode[7:4] == 4'h3) && !in_opcode[3] && in_opcode[0];

    assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);

    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_done && !wr_en && !hi_en && !br_taken));

    assert_high_half_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_en |-> (wr_en && hi_addr == RW'(HI_REG)));

    assert_zero_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && div_op && in_b == '0) |=> (wr_en && wr_data == '1 && div_err));

    assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |=> div_err);

    assert_always_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_opcode == 8'hC2) |=> (br_taken && br_target == $past(in_tgt)));

    assert_taken_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (next_pc == br_target));

    assert_branch_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |-> (!wr_en && !hi_en));

endmodule

bind seqx_exec_unit seqx_exec_chk #(
    .DW(DW), .RW(RW), .PCW(PCW), .HI_REG(HI_REG)
) i_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_tgt(in_tgt), .in_b(in_b), .out_done(out_done), .wr_en(wr_en),
    .wr_data(wr_data), .hi_en(hi_en), .hi_addr(hi_addr), .br_taken(br_taken),
    .br_target(br_target), .next_pc(next_pc), .div_err(div_err)
);

// File: tb/test_seqx_exec_unit.sv
// Directed bench for seqx_exec_unit: one task per scenario.
module test_seqx_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_opcode = '0;
    logic [15:0] in_pc = '0, in_tgt = '0, in_a = '0, in_b = '0;
    logic [7:0]  in_dst = '0;
    logic        out_done, wr_en, hi_en, br_taken, div_err;
    logic [7:0]  wr_addr, hi_addr;
    logic [15:0] wr_data, hi_data, br_target, next_pc;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    seqx_exec_unit i_seqx_exec_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_pc(in_pc), .in_dst(in_dst), .in_tgt(in_tgt), .in_a(in_a), .in_b(in_b),
        .out_done(out_done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hi_en(hi_en), .hi_addr(hi_addr), .hi_data(hi_data), .br_taken(br_taken),
        .br_target(br_target), .next_pc(next_pc), .div_err(div_err)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one instruction at a falling edge; results are sampled at the next one.
    task automatic issue(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] dst,
                         input logic [15:0] tgt, input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_opcode = op; in_pc = pc; in_dst = dst;
        in_tgt = tgt; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Expect a register write with no branch.
    task automatic exp_write(input string tag, input logic [7:0] dst, input logic [15:0] val,
                             input logic [15:0] npc);
        chk({tag, " done"}, 16'(out_done), 16'd1);
        chk({tag, " wr_en"}, 16'(wr_en), 16'd1);
        chk({tag, " wr_addr"}, 16'(wr_addr), 16'(dst));
        chk({tag, " wr_data"}, wr_data, val);
        chk({tag, " br_taken"}, 16'(br_taken), 16'd0);
        chk({tag, " next_pc"}, next_pc, npc);
    endtask

    // Expect a branch outcome with no register write.
    task automatic exp_branch(input string tag, input logic tk, input logic [15:0] npc);
        chk({tag, " done"}, 16'(out_done), 16'd1);
        chk({tag, " taken"}, 16'(br_taken), 16'(tk));
        chk({tag, " next_pc"}, next_pc, npc);
        chk({tag, " no write R10"}, 16'({wr_en, hi_en}), 16'd0);
    endtask

    task automatic t_reset_state;   // R11 and R1 idle
        chk("R11 done", 16'(out_done), 16'd0);
        chk("R11 wr_en", 16'(wr_en), 16'd0);
        chk("R11 next_pc", next_pc, 16'd0);
        chk("R11 div_err", 16'(div_err), 16'd0);
        @(negedge clk);
        chk("R1 idle done", 16'(out_done), 16'd0);
        chk("R1 idle taken", 16'(br_taken), 16'd0);
    endtask

    task automatic t_add_sub;   // R2, R9 lengths
        issue(8'h01, 16'h0100, 8'd5, 16'h0, 16'h7FFF, 16'h0001);
        exp_write("R2 add", 8'd5, 16'h8000, 16'h0104);
        issue(8'h07, 16'h0200, 8'd6, 16'h0, 16'hFFFF, 16'h0002);
        exp_write("R2 add wrap", 8'd6, 16'h0001, 16'h0206);
        issue(8'h13, 16'h0300, 8'd7, 16'h0, 16'h0005, 16'h0007);
        exp_write("R2 sub wrap", 8'd7, 16'hFFFE, 16'h0305);
        issue(8'h15, 16'h0310, 8'd8, 16'h0, 16'h0009, 16'h0004);
        exp_write("R9 sub imm2 len", 8'd8, 16'h0005, 16'h0315);
        @(negedge clk);
        chk("R1 one cycle only", 16'(out_done), 16'd0);
    endtask

    task automatic t_mul;   // R3
        issue(8'h21, 16'h0400, 8'd9, 16'h0, 16'h1234, 16'h0100);
        exp_write("R3 mul lo", 8'd9, 16'h3400, 16'h0404);
        chk("R3 hi_en", 16'(hi_en), 16'd1);
        chk("R3 hi_addr", 16'(hi_addr), 16'd199);
        chk("R3 hi_data", hi_data, 16'h0012);
        issue(8'h27, 16'h0410, 8'd10, 16'h0, 16'hFFFD, 16'h0005);
        exp_write("R3 mul neg lo", 8'd10, 16'hFFF1, 16'h0416);
        chk("R3 mul neg hi", hi_data, 16'hFFFF);
    endtask

    task automatic t_div;   // R4, R5
        issue(8'h31, 16'h0500, 8'd11, 16'h0, 16'h0007, 16'h0002);
        exp_write("R4 div", 8'd11, 16'h0003, 16'h0504);
        chk("R4 no hi", 16'(hi_en), 16'd0);
        issue(8'h33, 16'h0510, 8'd12, 16'h0, 16'hFFF9, 16'h0002);
        exp_write("R4 div toward zero", 8'd12, 16'hFFFD, 16'h0515);
        issue(8'h31, 16'h0520, 8'd13, 16'h0, 16'h8000, 16'hFFFF);
        exp_write("R4 div overflow", 8'd13, 16'h8000, 16'h0524);
        chk("R5 no err yet", 16'(div_err), 16'd0);
        issue(8'h31, 16'h0530, 8'd14, 16'h0, 16'h1234, 16'h0000);
        exp_write("R5 div zero", 8'd14, 16'hFFFF, 16'h0534);
        chk("R5 err set", 16'(div_err), 16'd1);
        issue(8'h31, 16'h0540, 8'd15, 16'h0, 16'h0006, 16'h0003);
        exp_write("R5 later div", 8'd15, 16'h0002, 16'h0544);
        chk("R5 err sticky", 16'(div_err), 16'd1);
    endtask

    task automatic t_step;   // R6
        issue(8'hC6, 16'h0600, 8'd20, 16'h0, 16'hFFFF, 16'h5555);
        exp_write("R6 inc wrap", 8'd20, 16'h0000, 16'h0602);
        issue(8'hD0, 16'h0610, 8'd21, 16'h0, 16'h0000, 16'h5555);
        exp_write("R6 dec wrap", 8'd21, 16'hFFFF, 16'h0612);
    endtask

    task automatic t_cmp_branch;   // R7, R9
        issue(8'h00, 16'h0700, 8'd0, 16'h1000, 16'h0042, 16'h0042);
        exp_branch("R7 eq taken", 1'b1, 16'h1000);
        chk("R7 target", br_target, 16'h1000);
        issue(8'h10, 16'h0710, 8'd0, 16'h1100, 16'h0042, 16'h0042);
        exp_branch("R7 ne fall R9", 1'b0, 16'h0714);
        issue(8'h2A, 16'h0720, 8'd0, 16'h1200, 16'hFFFF, 16'h0001);
        exp_branch("R7 lt signed", 1'b1, 16'h1200);
        issue(8'h50, 16'h0730, 8'd0, 16'h1300, 16'hFFFF, 16'h0001);
        exp_branch("R7 ge signed fall", 1'b0, 16'h0734);
        issue(8'h3A, 16'h0740, 8'd0, 16'h1400, 16'h0003, 16'h0003);
        exp_branch("R7 le equal", 1'b1, 16'h1400);
        issue(8'h48, 16'h0750, 8'd0, 16'h1500, 16'h0002, 16'h0001);
        exp_branch("R7 gt taken", 1'b1, 16'h1500);
        issue(8'h4A, 16'h0760, 8'd0, 16'h1600, 16'h0001, 16'h0001);
        exp_branch("R7 gt fall R9 len6", 1'b0, 16'h0766);
    endtask

    task automatic t_misc_branch;   // R8, R9
        issue(8'h86, 16'h0800, 8'd0, 16'h2000, 16'h0000, 16'h0000);
        exp_branch("R8 bnz fall R9 len4", 1'b0, 16'h0804);
        issue(8'h82, 16'h0810, 8'd0, 16'h2100, 16'h0005, 16'h0000);
        exp_branch("R8 bnz taken", 1'b1, 16'h2100);
        issue(8'h98, 16'h0820, 8'd0, 16'h2200, 16'h0000, 16'h0000);
        exp_branch("R8 bz taken", 1'b1, 16'h2200);
        issue(8'h90, 16'h0830, 8'd0, 16'h2300, 16'h0001, 16'h0000);
        exp_branch("R8 bz fall R9 len3", 1'b0, 16'h0833);
        issue(8'hCA, 16'h0840, 8'd0, 16'h2400, 16'h0000, 16'h0000);
        exp_branch("R8 jump", 1'b1, 16'h2400);
        issue(8'hC2, 16'h0850, 8'd0, 16'h2500, 16'h0000, 16'h0000);
        exp_branch("R8 jump reg", 1'b1, 16'h2500);
    endtask

    task automatic t_unknown;   // R10
        issue(8'hFF, 16'h0900, 8'd30, 16'h3000, 16'h0001, 16'h0001);
        exp_branch("R10 unknown", 1'b0, 16'h0901);
    endtask

    task automatic t_reset_clears;   // R11, R5
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 reset clears div_err R5", 16'(div_err), 16'd0);
        chk("R11 reset clears next_pc", next_pc, 16'd0);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_add_sub();
        t_mul();
        t_div();
        t_step();
        t_cmp_branch();
        t_misc_branch();
        t_unknown();
        t_reset_clears();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule